// File: doc/BRIEF.md
# Runtime-Configurable Asynchronous Serial Port

This block is a full-duplex asynchronous serial transmitter and receiver. Its character format is chosen at run time by one 8-bit configuration byte: a two-bit baud code, a 7-bit data mode, and even or odd parity. The surrounding logic supplies a single-cycle tick strobe at 128 times the slowest baud rate. All bit timing is counted in these ticks, so one divider serves all four speeds.

Characters to send arrive through a valid/ready handshake and are serialized least significant bit first. The line idles high, the start bit is low and the stop bit is high. On the receive side the line is sampled near the middle of each bit. Each character is delivered with a one-cycle valid strobe, a per-character parity flag and a framing flag. A parity flag that stays set until reset summarizes all parity errors seen.

The configuration is captured separately for each direction at the start of each frame. Software can therefore rewrite it at any time without damaging a character already on the wire. Buffering and flow control belong to a neighbouring block.

Top module: `rtcfgSerialPort`

## Requirements
- R1: After reset, txLine is high, txReady is high, rxValid, rxParErr and rxFrameErr are low, and parSticky is low.
- R2: Configuration bits [1:0] set the bit period in ticks: code 0 gives BASE_TICKS (128), code 1 gives BASE_TICKS/2 (64), code 2 gives BASE_TICKS/8 (16) and code 3 gives BASE_TICKS/16 (8). Time advances only on cycles where tick is high.
- R3: Configuration bit 5 set selects 7 data bits (clear selects 8). Bit 7 set selects odd parity, and bit 6 set selects even parity when bit 7 is clear. With both clear there is no parity. The frame is then 9, 10 or 11 bits (8 data bits + parity = 11, 7 data bits without parity = 9, otherwise 10). Byte 0x00 means 8 data bits, no parity, code 0.
- R4: A transmitted frame is a low start bit, the data bits least significant first, the parity bit if enabled, and one high stop bit. In 7-bit mode with parity, the parity takes the slot of data bit 7. Between frames the line stays high.
- R5: A character is accepted on a clock edge where txValid and txReady are both high. txReady then stays low until the stop bit has lasted one full bit period.
- R6: A receive frame begins when the synchronized line is low on a tick while the receiver is idle and has seen the line high since its last frame. The first data bit is sampled 1.5 bit periods later, and each following bit one bit period after the previous one.
- R7: Each received character is presented on rxData with a one-cycle rxValid pulse. In 7-bit mode bit 7 of rxData is 0.
- R8: When parity is enabled and the received parity bit disagrees with the parity of the received data, rxParErr is high together with rxValid. parSticky then stays high until reset.
- R9: A frame whose stop bit samples low is still delivered, with rxFrameErr high together with rxValid. No new frame starts until the line has returned high.
- R10: A configuration byte written while a frame is in progress does not change that frame's timing or format.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timing strobe at 128 times the slowest baud rate |
| cfgByte | input | 8 | Baud code [1:0], 7-bit mode [5], even parity [6], odd parity [7] |
| txData | input | 8 | Character to transmit |
| txValid | input | 1 | txData holds a character to send |
| txReady | output | 1 | Transmitter can accept a character |
| txLine | output | 1 | Serial output, idle high |
| rxLine | input | 1 | Serial input, idle high |
| rxData | output | 8 | Received character |
| rxValid | output | 1 | One-cycle strobe marking rxData |
| rxParErr | output | 1 | Parity mismatch on the delivered character |
| rxFrameErr | output | 1 | Stop bit sampled low on the delivered character |
| parSticky | output | 1 | Set by any parity error, cleared only by reset |

## Verification
A table of characters is sent and received under every format: 8 data bits with no, even and odd parity, and 7 data bits with each parity choice, at all four baud codes. The tx frame is decoded bit by bit, which separates a wrong frame length from a wrong parity slot or a wrong bit order. Characters chosen with an odd number of ones, a set bit 7, and all zeros distinguish even from odd parity and show the 7-bit masking. Directed cases cover a corrupted parity bit, a low stop bit and the re-arm behaviour after it, a configuration change in mid-frame, and a tick held low while a start bit is pending.

// File: rtl/serCfgPkg.sv
package serCfgPkg;

  typedef struct packed {
    logic txLoad;
    logic txShift;
    logic rxStart;
    logic rxSample;
    logic rxDone;
  } serStrobes_t;

  // bit period in ticks for a two-bit baud code
  function automatic int unsigned bitTicks(input logic [1:0] code, input int unsigned base);
    case (code)
      2'd0:    return base;
      2'd1:    return base / 2;
      2'd2:    return base / 8;
      default: return base / 16;
    endcase
  endfunction

  // total bits on the wire including start and stop
  function automatic logic [3:0] frameBits(input logic [7:0] cfg);
    return 4'd10 - {3'b0, cfg[5]} + {3'b0, cfg[6] | cfg[7]};
  endfunction

  // parity bit to send for data under cfg (odd wins over even)
  function automatic logic parityBit(input logic [7:0] d, input logic [7:0] cfg);
    logic p;
    p = cfg[5] ? ^d[6:0] : ^d;
    return cfg[7] ? ~p : p;
  endfunction

endpackage

// File: rtl/serCtrl.sv
module serCtrl
  import serCfgPkg::*;
#(
  parameter int unsigned BASE_TICKS = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        tick,
  input  logic [7:0]  cfgByte,
  input  logic        txValid,
  input  logic        rxLine,
  output logic        txReady,
  output logic        rxBit,
  output serStrobes_t st
);

  localparam int unsigned TW = $clog2(BASE_TICKS + BASE_TICKS / 2 + 1);

  // transmit timing
  logic          txBusy;
  logic [3:0]    txLeft;
  logic [TW-1:0] txCnt;
  logic [1:0]    txBaud;
  logic [TW-1:0] txReload;
  logic          txLoadC, txShiftC;

  assign txReload = TW'(bitTicks(txBaud, BASE_TICKS));
  assign txLoadC  = txValid & ~txBusy;
  assign txShiftC = txBusy & tick & (txCnt == TW'(1));
  assign txReady  = ~txBusy;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0;
      txLeft <= '0;
      txCnt  <= '0;
      txBaud <= '0;
    end else if (txLoadC) begin
      txBusy <= 1'b1;
      txLeft <= frameBits(cfgByte);
      txCnt  <= TW'(bitTicks(cfgByte[1:0], BASE_TICKS));
      txBaud <= cfgByte[1:0];
    end else if (txShiftC) begin
      txCnt  <= txReload;
      txLeft <= txLeft - 4'd1;
      if (txLeft == 4'd1) txBusy <= 1'b0;
    end else if (txBusy && tick) begin
      txCnt <= txCnt - TW'(1);
    end
  end

  // receive timing
  logic [1:0]    rxSync;
  logic          rxBusy, rxArmed, rxDoneQ;
  logic [3:0]    rxLeft;
  logic [TW-1:0] rxCnt;
  logic [1:0]    rxBaud;
  logic [TW-1:0] rxReload;
  logic          rxStartC, rxSampleC;

  assign rxBit     = rxSync[1];
  assign rxReload  = TW'(bitTicks(rxBaud, BASE_TICKS));
  assign rxStartC  = ~rxBusy & rxArmed & tick & ~rxBit;
  assign rxSampleC = rxBusy & tick & (rxCnt == TW'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxSync  <= 2'b11;
      rxBusy  <= 1'b0;
      rxArmed <= 1'b0;
      rxDoneQ <= 1'b0;
      rxLeft  <= '0;
      rxCnt   <= '0;
      rxBaud  <= '0;
    end else begin
      rxSync  <= {rxSync[0], rxLine};
      rxDoneQ <= rxSampleC && (rxLeft == 4'd1);
      if (rxStartC) begin
        rxBusy  <= 1'b1;
        rxArmed <= 1'b0;
        rxLeft  <= frameBits(cfgByte) - 4'd1;
        rxCnt   <= TW'(bitTicks(cfgByte[1:0], BASE_TICKS)
                     + bitTicks(cfgByte[1:0], BASE_TICKS) / 2);
        rxBaud  <= cfgByte[1:0];
      end else begin
        if (!rxBusy && rxBit) rxArmed <= 1'b1;
        if (rxSampleC) begin
          rxCnt  <= rxReload;
          rxLeft <= rxLeft - 4'd1;
          if (rxLeft == 4'd1) rxBusy <= 1'b0;
        end else if (rxBusy && tick) begin
          rxCnt <= rxCnt - TW'(1);
        end
      end
    end
  end

  always_comb begin
    st.txLoad   = txLoadC;
    st.txShift  = txShiftC;
    st.rxStart  = rxStartC;
    st.rxSample = rxSampleC;
    st.rxDone   = rxDoneQ;
  end

endmodule

// File: rtl/serDatapath.sv
module serDatapath
  import serCfgPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  serStrobes_t st,
  input  logic [7:0]  cfgByte,
  input  logic [7:0]  txData,
  input  logic        rxBit,
  output logic        txLine,
  output logic [7:0]  rxData,
  output logic        rxValid,
  output logic        rxParErr,
  output logic        rxFrameErr,
  output logic        parSticky
);

  // transmit frame, bit 0 first on the wire
  logic [10:0] txSh, txFrame;
  logic [7:0]  txPay;
  logic        txPar, txParEn;

  always_comb begin
    txParEn = cfgByte[6] | cfgByte[7];
    txPar   = parityBit(txData, cfgByte);
    txPay   = txData;
    if (cfgByte[5]) txPay[7] = txParEn ? txPar : 1'b1;
    txFrame = {1'b1, (txParEn && !cfgByte[5]) ? txPar : 1'b1, txPay, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (!rstN)           txSh <= '1;
    else if (st.txLoad)  txSh <= txFrame;
    else if (st.txShift) txSh <= {1'b1, txSh[10:1]};
  end

  assign txLine = txSh[0];

  // receive: bits after the start bit enter at the top
  logic [2:0] rxFmt;
  logic [9:0] rxSh, rxAlign;
  logic [3:0] rxN;
  logic [7:0] rxWord;
  logic       rxParBit, rxStopBit, rxParBad;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxFmt <= '0;
      rxSh  <= '1;
    end else begin
      if (st.rxStart)  rxFmt <= cfgByte[7:5];
      if (st.rxSample) rxSh  <= {rxBit, rxSh[9:1]};
    end
  end

  always_comb begin
    rxN       = frameBits({rxFmt, 5'b0}) - 4'd1;
    rxAlign   = rxSh >> (4'd10 - rxN);
    rxWord    = rxFmt[0] ? {1'b0, rxAlign[6:0]} : rxAlign[7:0];
    rxParBit  = rxFmt[0] ? rxAlign[7] : rxAlign[8];
    rxStopBit = rxAlign[rxN - 4'd1];
    rxParBad  = (rxFmt[1] | rxFmt[2]) && (rxParBit != parityBit(rxWord, {rxFmt, 5'b0}));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxData     <= '0;
      rxValid    <= 1'b0;
      rxParErr   <= 1'b0;
      rxFrameErr <= 1'b0;
      parSticky  <= 1'b0;
    end else if (st.rxDone) begin
      rxData     <= rxWord;
      rxValid    <= 1'b1;
      rxParErr   <= rxParBad;
      rxFrameErr <= ~rxStopBit;
      if (rxParBad) parSticky <= 1'b1;
    end else begin
      rxValid    <= 1'b0;
      rxParErr   <= 1'b0;
      rxFrameErr <= 1'b0;
    end
  end

endmodule

// File: rtl/rtcfgSerialPort.sv
module rtcfgSerialPort
  import serCfgPkg::*;
#(
  parameter int unsigned BASE_TICKS = 128
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic [7:0] cfgByte,
  input  logic [7:0] txData,
  input  logic       txValid,
  output logic       txReady,
  output logic       txLine,
  input  logic       rxLine,
  output logic [7:0] rxData,
  output logic       rxValid,
  output logic       rxParErr,
  output logic       rxFrameErr,
  output logic       parSticky
);

  serStrobes_t st;
  logic        rxBit;

  serCtrl #(.BASE_TICKS(BASE_TICKS)) uCtrl (
    .clk(clk), .rstN(rstN), .tick(tick), .cfgByte(cfgByte),
    .txValid(txValid), .rxLine(rxLine), .txReady(txReady),
    .rxBit(rxBit), .st(st)
  );

  serDatapath uPath (
    .clk(clk), .rstN(rstN), .st(st), .cfgByte(cfgByte), .txData(txData),
    .rxBit(rxBit), .txLine(txLine), .rxData(rxData), .rxValid(rxValid),
    .rxParErr(rxParErr), .rxFrameErr(rxFrameErr), .parSticky(parSticky)
  );

endmodule

// File: rtl/serPortChecker.sv
module serPortChecker (
  input logic clk,
  input logic rstN,
  input logic txValid,
  input logic txReady,
  input logic txLine,
  input logic rxValid,
  input logic rxParErr,
  input logic rxFrameErr,
  input logic parSticky
);

  // R4
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txLine);

  // R5
  busy_needs_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(txReady) |-> $past(txValid));

  // R5
  accept_starts_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txReady) |=> (!txLine && !txReady));

  // R7
  valid_single_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |=> !rxValid);

  // R8
  sticky_holds_chk: assert property (@(posedge clk) disable iff (!rstN)
    parSticky |=> parSticky);

  // R8
  par_err_sets_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxParErr |-> (parSticky && rxValid));

  // R9
  frame_err_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    rxFrameErr |-> rxValid);

endmodule

bind rtcfgSerialPort serPortChecker uChk (
  .clk(clk), .rstN(rstN), .txValid(txValid), .txReady(txReady),
  .txLine(txLine), .rxValid(rxValid), .rxParErr(rxParErr),
  .rxFrameErr(rxFrameErr), .parSticky(parSticky)
);

// File: tb/tb_rtcfgSerialPort.sv
module tb_rtcfgSerialPort;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // {cfgByte, character}
  localparam logic [15:0] VEC [NVEC] = '{
    16'h03A5, 16'h4237, 16'h8337, 16'h23C5,
    16'h6351, 16'hA17F, 16'h4300, 16'h0081
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tick = 1'b1;
  logic [7:0] cfgByte = 8'h00;
  logic [7:0] txData = 8'h00;
  logic txValid = 1'b0;
  logic txReady, txLine;
  logic rxLine = 1'b1;
  logic [7:0] rxData;
  logic rxValid, rxParErr, rxFrameErr, parSticky;

  int nChecks = 0;
  int nFails = 0;
  int capCount = 0;
  logic [7:0] capData = '0;
  logic capPar = 1'b0;
  logic capFrm = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtcfgSerialPort dut (
    .clk(clk), .rstN(rstN), .tick(tick), .cfgByte(cfgByte), .txData(txData),
    .txValid(txValid), .txReady(txReady), .txLine(txLine), .rxLine(rxLine),
    .rxData(rxData), .rxValid(rxValid), .rxParErr(rxParErr),
    .rxFrameErr(rxFrameErr), .parSticky(parSticky)
  );

  always @(negedge clk) begin
    if (rxValid) begin
      capCount <= capCount + 1;
      capData  <= rxData;
      capPar   <= rxParErr;
      capFrm   <= rxFrameErr;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int periodOf(input logic [7:0] cfg);
    case (cfg[1:0])
      2'd0: return 128;
      2'd1: return 64;
      2'd2: return 16;
      default: return 8;
    endcase
  endfunction

  // wire frame per R3/R4, returns bit count
  function automatic int buildBits(input logic [7:0] cfg, input logic [7:0] d, output logic [10:0] b);
    int dl, k, ones;
    bit parOn;
    logic p;
    b = '1;
    dl = cfg[5] ? 7 : 8;
    parOn = cfg[6] || cfg[7];
    ones = 0;
    b[0] = 1'b0;
    k = 1;
    for (int i = 0; i < dl; i++) begin
      b[k] = d[i];
      if (d[i]) ones++;
      k++;
    end
    if (parOn) begin
      p = cfg[7] ? ((ones % 2) == 0) : ((ones % 2) == 1);
      b[k] = p;
      k++;
    end
    b[k] = 1'b1;
    return k + 1;
  endfunction

  task automatic sendTx(input logic [7:0] cfg, input logic [7:0] d, input logic [7:0] cfgAfter, input string req);
    logic [10:0] expB, got;
    int n, p;
    n = buildBits(cfg, d, expB);
    p = periodOf(cfg);
    got = '1;
    @(negedge clk);
    cfgByte = cfg; txData = d; txValid = 1'b1;
    while (!txReady) @(negedge clk);
    @(negedge clk);
    txValid = 1'b0;
    cfgByte = cfgAfter;
    repeat (p/2 - 1) @(negedge clk);
    got[0] = txLine;
    for (int i = 1; i < n; i++) begin
      repeat (p) @(negedge clk);
      got[i] = txLine;
    end
    chk(got == expB, {req, " tx frame bits"}, 32'(got), 32'(expB));
    chk(txReady == 1'b0, "R5 busy through stop bit", 32'(txReady), 32'd0);
    repeat (p) @(negedge clk);
    chk(txReady && txLine, "R5 ready and idle after stop", {30'd0, txReady, txLine}, 32'd3);
    cfgByte = cfg;
  endtask

  task automatic sendRx(input logic [7:0] cfg, input logic [7:0] d, input bit badPar, input bit stopLow);
    logic [10:0] b;
    int n, p;
    n = buildBits(cfg, d, b);
    p = periodOf(cfg);
    if (badPar) b[n-2] = ~b[n-2];
    if (stopLow) b[n-1] = 1'b0;
    @(negedge clk);
    cfgByte = cfg;
    for (int i = 0; i < n; i++) begin
      rxLine = b[i];
      repeat (p) @(negedge clk);
    end
    rxLine = 1'b1;
    repeat (p + 12) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finishRun();
    end
  end

  initial begin
    int c0;
    logic [7:0] expD;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk({txLine, txReady, rxValid, rxParErr, rxFrameErr, parSticky} == 6'b110000,
        "R1 reset outputs", {26'd0, txLine, txReady, rxValid, rxParErr, rxFrameErr, parSticky}, 32'h30);
    rstN = 1'b1;
    repeat (4) @(negedge clk);

    // table of formats and baud codes: R2 R3 R4 R6 R7
    for (int v = 0; v < NVEC; v++) begin
      sendTx(VEC[v][15:8], VEC[v][7:0], VEC[v][15:8], "R2 R3 R4");
      c0 = capCount;
      sendRx(VEC[v][15:8], VEC[v][7:0], 1'b0, 1'b0);
      expD = VEC[v][13] ? {1'b0, VEC[v][6:0]} : VEC[v][7:0];
      chk(capCount == c0 + 1, "R6 one character delivered", 32'(capCount - c0), 32'd1);
      chk(capData == expD, "R7 received data", 32'(capData), 32'(expD));
      chk(!capPar && !capFrm, "R8 R9 no flags on clean frame", {30'd0, capPar, capFrm}, 32'd0);
    end

    // R8 parity error on an 8-bit even-parity frame
    c0 = capCount;
    sendRx(8'h43, 8'h96, 1'b1, 1'b0);
    chk(capCount == c0 + 1 && capData == 8'h96, "R8 data still delivered", 32'(capData), 32'h96);
    chk(capPar == 1'b1, "R8 rxParErr on bad parity", 32'(capPar), 32'd1);
    chk(parSticky == 1'b1, "R8 sticky set", 32'(parSticky), 32'd1);
    sendRx(8'h43, 8'h96, 1'b0, 1'b0);
    chk(capPar == 1'b0 && parSticky == 1'b1, "R8 sticky holds after clean frame",
        {30'd0, capPar, parSticky}, 32'd1);

    // R9 low stop bit, then re-arm only after line high
    c0 = capCount;
    sendRx(8'h03, 8'h3C, 1'b0, 1'b1);
    chk(capFrm == 1'b1 && capData == 8'h3C, "R9 framing flag with data", {23'd0, capFrm, capData}, 32'h13C);
    repeat (60) @(negedge clk);
    chk(capCount == c0 + 1, "R9 no spurious frame", 32'(capCount - c0), 32'd1);

    // R10 configuration rewritten mid-frame
    sendTx(8'h03, 8'hA5, 8'hA0, "R10 mid-frame config");

    // R2 no progress without tick
    @(negedge clk);
    cfgByte = 8'h03; txData = 8'h55; txValid = 1'b1; tick = 1'b0;
    @(negedge clk);
    txValid = 1'b0;
    repeat (200) @(negedge clk);
    chk(txLine == 1'b0 && txReady == 1'b0, "R2 start bit held without tick",
        {30'd0, txLine, txReady}, 32'd0);
    tick = 1'b1;
    repeat (120) @(negedge clk);
    chk(txReady == 1'b1, "R2 frame completes once tick resumes", 32'(txReady), 32'd1);

    done = 1'b1;
    finishRun();
  end

endmodule